// File: doc/BRIEF.md
# Local Scan Chain Configurator

This block sits behind a scan gateway's test access port and decides which of three downstream scan ports take part in the serial path. The gateway's own TAP controller is outside the block; it supplies its current controller state and the instruction held in its instruction register. The block keeps an 8-bit port-select register, loaded serially through its own data register, and one park controller per port. A port carries scan traffic only when it is selected and not parked. Active ports are spliced in, always in ascending port order and each followed by a single retiming flop, between the serial output of the gateway's internal register and the chain output.

Parking freezes a downstream port in a stable controller state (reset, idle or a pause state) by holding its mode-select line at the value that keeps it there. This lets the upstream controller run other operations while the local devices wait. Parking and unparking happen only while the gateway controller itself sits in the matching stable state, so the two controllers stay in step. When no port is active, the internal register output goes straight to the chain output.

Top module: `lscan_router`

## Requirements
- R1: While `rst_n` is low and after it, before any load, every port is unparked and unselected: each `lsp_tdi` bit is 1, `chain_tdo` equals `core_so`, and each `lsp_tms` bit equals `prim_tms`.
- R2: `tap_state` uses the codes Test-Logic-Reset 4'hF, Run-Test/Idle 4'hC, Shift-DR 4'h2, Update-DR 4'h5, Pause-DR 4'h3 and Pause-IR 4'hB. With `ir_value` 8'h8E, each rising `tck` in Shift-DR shifts `prim_tdi` into the select shift register (the first bit shifted lands in bit 0 after eight shifts), and a rising edge in Update-DR copies it into the select register. Shifting or updating under any other instruction leaves the select register unchanged.
- R3: Select bits 0, 1 and 2 choose ports 0, 1 and 2. Bits 7 to 3 have no effect on routing.
- R4: Active ports form the path `core_so`, port 0, pad, port 1, pad, port 2, pad, `chain_tdo`, skipping inactive ports. The first active port's `lsp_tdi` equals `core_so`. Each later active port, or `chain_tdo`, sees the value its predecessor's `lsp_tdo` had at the previous rising `tck`.
- R5: An inactive port has `lsp_tdi` at 1. With no active port, `chain_tdo` equals `core_so` in the same cycle.
- R6: A rising edge in Test-Logic-Reset clears the select register to zero. A park or unpark decision made on that same edge uses the select value from before the clear.
- R7: Selected unparked ports become parked on a rising edge where `ir_value`/`tap_state` is 8'hC5/Test-Logic-Reset (reset park), 8'h84/Run-Test/Idle (idle park), or 8'hC6/Pause-DR or Pause-IR (pause park). Any other combination, or an unselected port, is left unparked.
- R8: A port parked in reset drives `lsp_tms` 1. A port parked in idle or pause drives `lsp_tms` 0. An unparked port drives `prim_tms`, whether it is selected or not.
- R9: With `ir_value` 8'hE7, a selected parked port unparks on a rising edge only when `tap_state` matches its parked state (either pause state for a pause park). Otherwise it stays parked.
- R10: A parked port is out of the chain even when it is selected.
- R11: Each `lsp_tck` bit is a copy of `tck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock from the primary port |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_state | input | 4 | Current state of the gateway TAP controller |
| ir_value | input | IR_W (8) | Instruction currently held by the gateway |
| prim_tms | input | 1 | Primary mode-select line |
| prim_tdi | input | 1 | Primary serial data input |
| core_so | input | 1 | Serial output of the gateway's selected internal register |
| lsp_tdo | input | N_PORT (3) | Serial data returning from each downstream port |
| lsp_tck | output | N_PORT (3) | Test clock forwarded to each port |
| lsp_tms | output | N_PORT (3) | Mode-select line driven to each port |
| lsp_tdi | output | N_PORT (3) | Serial data driven into each port |
| chain_tdo | output | 1 | End of the assembled chain, toward primary TDO |

## Verification
A reset-state park and the clearing of the select register both act on the same edge, when the gateway enters Test-Logic-Reset. The bench loads a select value covering two ports, presents the reset-park instruction and drives one Test-Logic-Reset cycle. It then checks that exactly those two ports now hold mode-select at 1 while the third still follows the primary line. It also checks that no port is left in the chain. Unparking is checked the same way, with the gateway returning to Test-Logic-Reset under the unpark instruction. After that, a fresh select load must show the previously parked ports back in the chain.

// File: rtl/lscan_pkg.sv
package lscan_pkg;

  typedef enum logic [3:0] {
    TS_EXIT2_DR   = 4'h0,
    TS_EXIT1_DR   = 4'h1,
    TS_SHIFT_DR   = 4'h2,
    TS_PAUSE_DR   = 4'h3,
    TS_SEL_IR     = 4'h4,
    TS_UPDATE_DR  = 4'h5,
    TS_CAPTURE_DR = 4'h6,
    TS_SEL_DR     = 4'h7,
    TS_EXIT2_IR   = 4'h8,
    TS_EXIT1_IR   = 4'h9,
    TS_SHIFT_IR   = 4'hA,
    TS_PAUSE_IR   = 4'hB,
    TS_IDLE       = 4'hC,
    TS_UPDATE_IR  = 4'hD,
    TS_CAPTURE_IR = 4'hE,
    TS_RESET      = 4'hF
  } tap_state_e;

  // Park controller state codes
  localparam logic [1:0] PK_RUN   = 2'd0;
  localparam logic [1:0] PK_RESET = 2'd1;
  localparam logic [1:0] PK_IDLE  = 2'd2;
  localparam logic [1:0] PK_PAUSE = 2'd3;

  // Instruction codes recognised by this block
  localparam logic [7:0] OP_SELECT_LOAD = 8'h8E;
  localparam logic [7:0] OP_PARK_RESET  = 8'hC5;
  localparam logic [7:0] OP_PARK_IDLE   = 8'h84;
  localparam logic [7:0] OP_PARK_PAUSE  = 8'hC6;
  localparam logic [7:0] OP_UNPARK      = 8'hE7;

endpackage

// File: rtl/lscan_select_reg.sv
module lscan_select_reg
  import lscan_pkg::*;
#(
  parameter int MODE_W = 8,
  parameter int IR_W   = 8
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic [3:0]        tap_state,
  input  logic [IR_W-1:0]   ir_value,
  input  logic              prim_tdi,
  output logic [MODE_W-1:0] mode_q
);

  logic [MODE_W-1:0] shift_q, shift_d;
  logic [MODE_W-1:0] mode_d;
  logic              is_load_ir;

  assign is_load_ir = (ir_value == IR_W'(OP_SELECT_LOAD));

  always_comb begin
    shift_d = shift_q;
    mode_d  = mode_q;
    if (is_load_ir && tap_state == TS_SHIFT_DR) begin
      shift_d = {prim_tdi, shift_q[MODE_W-1:1]};
    end
    if (tap_state == TS_RESET) begin
      mode_d = '0;
    end else if (is_load_ir && tap_state == TS_UPDATE_DR) begin
      mode_d = shift_q;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      mode_q  <= '0;
    end else begin
      shift_q <= shift_d;
      mode_q  <= mode_d;
    end
  end

endmodule

// File: rtl/lscan_park_fsm.sv
module lscan_park_fsm
  import lscan_pkg::*;
#(
  parameter int IR_W = 8
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic [3:0]      tap_state,
  input  logic [IR_W-1:0] ir_value,
  input  logic            selected,
  input  logic            prim_tms,
  output logic [1:0]      park_code,
  output logic            parked,
  output logic            port_tms
);

  logic [1:0] cur_q, nxt;
  logic       in_pause, at_own_state;

  assign in_pause     = (tap_state == TS_PAUSE_DR) || (tap_state == TS_PAUSE_IR);
  assign at_own_state = ((cur_q == PK_RESET) && (tap_state == TS_RESET)) ||
                        ((cur_q == PK_IDLE)  && (tap_state == TS_IDLE))  ||
                        ((cur_q == PK_PAUSE) && in_pause);

  always_comb begin
    nxt = cur_q;
    if (selected) begin
      if (cur_q == PK_RUN) begin
        if (ir_value == IR_W'(OP_PARK_RESET) && tap_state == TS_RESET) begin
          nxt = PK_RESET;
        end else if (ir_value == IR_W'(OP_PARK_IDLE) && tap_state == TS_IDLE) begin
          nxt = PK_IDLE;
        end else if (ir_value == IR_W'(OP_PARK_PAUSE) && in_pause) begin
          nxt = PK_PAUSE;
        end
      end else if (ir_value == IR_W'(OP_UNPARK) && at_own_state) begin
        nxt = PK_RUN;
      end
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= PK_RUN;
    end else begin
      cur_q <= nxt;
    end
  end

  always_comb begin
    unique case (cur_q)
      PK_RUN:   port_tms = prim_tms;
      PK_RESET: port_tms = 1'b1;
      default:  port_tms = 1'b0;
    endcase
  end

  assign park_code = cur_q;
  assign parked    = (cur_q != PK_RUN);

endmodule

// File: rtl/lscan_chain.sv
module lscan_chain #(
  parameter int N_PORT = 3
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic [N_PORT-1:0] active,
  input  logic              core_so,
  input  logic [N_PORT-1:0] lsp_tdo,
  output logic [N_PORT-1:0] lsp_tdi,
  output logic              chain_tdo
);

  logic [N_PORT-1:0] pad_q, pad_d;

  genvar g;
  generate
    for (g = 0; g < N_PORT; g++) begin : g_pad
      assign pad_d[g] = active[g] ? lsp_tdo[g] : pad_q[g];

      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
          pad_q[g] <= 1'b0;
        end else begin
          pad_q[g] <= pad_d[g];
        end
      end
    end
  endgenerate

  // Walk the ports in ascending order, splicing in each active one
  always_comb begin
    logic carry;
    carry = core_so;
    for (int i = 0; i < N_PORT; i++) begin
      lsp_tdi[i] = active[i] ? carry : 1'b1;
      if (active[i]) begin
        carry = pad_q[i];
      end
    end
    chain_tdo = carry;
  end

endmodule

// File: rtl/lscan_router.sv
module lscan_router
  import lscan_pkg::*;
#(
  parameter int N_PORT = 3,
  parameter int MODE_W = 8,
  parameter int IR_W   = 8
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic [3:0]        tap_state,
  input  logic [IR_W-1:0]   ir_value,
  input  logic              prim_tms,
  input  logic              prim_tdi,
  input  logic              core_so,
  input  logic [N_PORT-1:0] lsp_tdo,
  output logic [N_PORT-1:0] lsp_tck,
  output logic [N_PORT-1:0] lsp_tms,
  output logic [N_PORT-1:0] lsp_tdi,
  output logic              chain_tdo
);

  logic [MODE_W-1:0]      mode_q;
  logic [N_PORT-1:0]      parked;
  logic [N_PORT-1:0]      active;
  logic [N_PORT-1:0][1:0] park_code;

  lscan_select_reg #(.MODE_W(MODE_W), .IR_W(IR_W)) u_sel (
    .tck       (tck),
    .rst_n     (rst_n),
    .tap_state (tap_state),
    .ir_value  (ir_value),
    .prim_tdi  (prim_tdi),
    .mode_q    (mode_q)
  );

  genvar g;
  generate
    for (g = 0; g < N_PORT; g++) begin : g_port
      lscan_park_fsm #(.IR_W(IR_W)) u_park (
        .tck       (tck),
        .rst_n     (rst_n),
        .tap_state (tap_state),
        .ir_value  (ir_value),
        .selected  (mode_q[g]),
        .prim_tms  (prim_tms),
        .park_code (park_code[g]),
        .parked    (parked[g]),
        .port_tms  (lsp_tms[g])
      );
      assign active[g]  = mode_q[g] & ~parked[g];
      assign lsp_tck[g] = tck;
    end
  endgenerate

  lscan_chain #(.N_PORT(N_PORT)) u_chain (
    .tck       (tck),
    .rst_n     (rst_n),
    .active    (active),
    .core_so   (core_so),
    .lsp_tdo   (lsp_tdo),
    .lsp_tdi   (lsp_tdi),
    .chain_tdo (chain_tdo)
  );

endmodule

// File: rtl/lscan_router_chk.sv
module lscan_router_chk
  import lscan_pkg::*;
#(
  parameter int N_PORT = 3,
  parameter int MODE_W = 8,
  parameter int IR_W   = 8
) (
  input logic                   tck,
  input logic                   rst_n,
  input logic [3:0]             tap_state,
  input logic [IR_W-1:0]        ir_value,
  input logic [N_PORT-1:0]      lsp_tms,
  input logic [N_PORT-1:0]      lsp_tdi,
  input logic [MODE_W-1:0]      mode_q,
  input logic [N_PORT-1:0][1:0] park_code
);

  // R6: entering reset clears the select register
  p_select_clear_r6: assert property (@(posedge tck) disable iff (!rst_n)
    (tap_state == TS_RESET) |=> (mode_q == '0));

  // R2: select register only moves on update or reset
  p_select_hold_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (tap_state != TS_UPDATE_DR && tap_state != TS_RESET) |=> $stable(mode_q));

  // R9: park state can change only in a stable controller state
  p_park_hold_r9: assert property (@(posedge tck) disable iff (!rst_n)
    (tap_state != TS_RESET && tap_state != TS_IDLE &&
     tap_state != TS_PAUSE_DR && tap_state != TS_PAUSE_IR) |=> $stable(park_code));

  genvar g;
  generate
    for (g = 0; g < N_PORT; g++) begin : g_chk
      // R5: unselected port sees a constant 1
      p_unselected_tdi_r5: assert property (@(posedge tck) disable iff (!rst_n)
        !mode_q[g] |-> lsp_tdi[g]);

      // R10: parked port is out of the chain
      p_parked_out_r10: assert property (@(posedge tck) disable iff (!rst_n)
        (park_code[g] != PK_RUN) |-> lsp_tdi[g]);

      // R7/R8: idle park drives mode-select low from the next cycle
      p_idle_park_tms_r7: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_value == IR_W'(OP_PARK_IDLE) && tap_state == TS_IDLE &&
         mode_q[g] && park_code[g] == PK_RUN) |=> !lsp_tms[g]);
    end
  endgenerate

endmodule

bind lscan_router lscan_router_chk #(
  .N_PORT (N_PORT),
  .MODE_W (MODE_W),
  .IR_W   (IR_W)
) u_chk (
  .tck       (tck),
  .rst_n     (rst_n),
  .tap_state (tap_state),
  .ir_value  (ir_value),
  .lsp_tms   (lsp_tms),
  .lsp_tdi   (lsp_tdi),
  .mode_q    (mode_q),
  .park_code (park_code)
);

// File: tb/lscan_router_tb_top.sv
module lscan_router_tb_top;
  import lscan_pkg::*;

  localparam int N = 3;

  logic         tck = 1'b0;
  logic         rst_n;
  logic [3:0]   tap;
  logic [7:0]   ir;
  logic         prim_tms, prim_tdi, core_so;
  logic [N-1:0] ltdo, ltck, ltms, ltdi;
  logic         tdo;

  always #4 tck = ~tck;

  lscan_router dut_i (
    .tck (tck), .rst_n (rst_n), .tap_state (tap), .ir_value (ir),
    .prim_tms (prim_tms), .prim_tdi (prim_tdi), .core_so (core_so),
    .lsp_tdo (ltdo), .lsp_tck (ltck), .lsp_tms (ltms), .lsp_tdi (ltdi),
    .chain_tdo (tdo)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Expected state kept by the bench: 0 run, 1 reset park, 2 idle park, 3 pause park
  logic [2:0] exp_mode;
  logic [1:0] exp_park [N];
  logic       m_pad    [N];

  function automatic logic [N-1:0] exp_act();
    logic [N-1:0] a;
    for (int i = 0; i < N; i++) a[i] = exp_mode[i] && (exp_park[i] == 2'd0);
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int unsigned act, input int unsigned expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic tick();
    logic [N-1:0] a;
    @(posedge tck);
    a = exp_act();
    for (int i = 0; i < N; i++) if (a[i]) m_pad[i] = ltdo[i];
    @(negedge tck);
  endtask

  task automatic check_route(input string req, input int n);
    logic [N-1:0] a, et;
    logic carry;
    for (int k = 0; k < n; k++) begin
      core_so = k[0] ^ k[2];
      ltdo    = 3'((k * 5 + 3) ^ (k >> 1));
      #1;
      a = exp_act();
      carry = core_so;
      for (int i = 0; i < N; i++) begin
        et[i] = a[i] ? carry : 1'b1;
        if (a[i]) carry = m_pad[i];
      end
      chk({ltdi, tdo} == {et, carry}, req, "route {lsp_tdi,chain_tdo}",
          {ltdi, tdo}, {et, carry});
      tick();
    end
  endtask

  task automatic check_tms(input string req);
    logic [N-1:0] e;
    for (int p = 0; p < 2; p++) begin
      prim_tms = p[0];
      #1;
      for (int i = 0; i < N; i++)
        e[i] = (exp_park[i] == 2'd0) ? p[0] : (exp_park[i] == 2'd1);
      chk(ltms == e, req, "lsp_tms", ltms, e);
    end
    tick();
  endtask

  task automatic load_mode(input logic [7:0] v);
    ir  = OP_SELECT_LOAD;
    tap = TS_SHIFT_DR;
    for (int k = 0; k < 8; k++) begin
      prim_tdi = v[k];
      tick();
    end
    tap = TS_UPDATE_DR;
    tick();
    exp_mode = v[2:0];
    tap = TS_IDLE;
  endtask

  task automatic step(input logic [7:0] iv, input logic [3:0] tv);
    ir  = iv;
    tap = tv;
    tick();
    tap = TS_IDLE;
    ir  = 8'hFF;
  endtask

  initial begin
    rst_n = 1'b0; tap = TS_RESET; ir = 8'hFF;
    prim_tms = 1'b0; prim_tdi = 1'b0; core_so = 1'b0; ltdo = '0;
    exp_mode = '0;
    for (int i = 0; i < N; i++) begin exp_park[i] = 2'd0; m_pad[i] = 1'b0; end
    repeat (3) @(negedge tck);
    rst_n = 1'b1;
    tap = TS_IDLE;

    // R1: state out of reset
    check_route("R1", 2);
    check_tms("R1");
    // R11: clock forwarding, both phases
    #1;
    chk(ltck == 3'b000, "R11", "lsp_tck low phase", ltck, 0);
    @(posedge tck); #1;
    chk(ltck == 3'b111, "R11", "lsp_tck high phase", ltck, 7);
    @(negedge tck);

    // R3, R4, R5: every low select value, varied upper bits
    for (int v = 0; v < 32; v++) begin
      load_mode({5'(v) ^ 5'b10110, 3'(v)});
      check_route("R3/R4", 6);
    end

    // R2: shifting and updating under another instruction leaves select alone
    load_mode(8'h07);
    ir = 8'hFF; tap = TS_SHIFT_DR;
    for (int k = 0; k < 8; k++) begin prim_tdi = 1'b0; tick(); end
    tap = TS_UPDATE_DR; tick(); tap = TS_IDLE;
    check_route("R2", 3);

    // R6: reset state clears select
    step(8'hFF, TS_RESET);
    exp_mode = '0;
    check_route("R6", 3);

    // R7: park with mismatched state has no effect; then idle park
    load_mode(8'h07);
    step(OP_PARK_PAUSE, TS_IDLE);
    check_tms("R7");
    step(OP_PARK_IDLE, TS_IDLE);
    for (int i = 0; i < N; i++) exp_park[i] = 2'd2;
    check_tms("R8");
    check_route("R10", 3);
    // R9: unpark outside the parked state is ignored
    step(OP_UNPARK, TS_SHIFT_DR);
    step(OP_UNPARK, TS_PAUSE_DR);
    check_tms("R9");
    step(OP_UNPARK, TS_IDLE);
    for (int i = 0; i < N; i++) exp_park[i] = 2'd0;
    check_tms("R9");
    check_route("R9", 3);

    // R7: pause park of one port via Pause-IR; others stay in chain
    load_mode(8'h02);
    step(OP_PARK_PAUSE, TS_PAUSE_IR);
    exp_park[1] = 2'd3;
    load_mode(8'hF7);
    check_tms("R8");
    check_route("R10", 4);
    step(OP_PARK_RESET, TS_IDLE);
    check_tms("R7");
    step(OP_UNPARK, TS_PAUSE_DR);
    exp_park[1] = 2'd0;
    check_route("R9", 4);

    // R6 with R7: reset park and select clear on the same edge
    load_mode(8'h05);
    step(OP_PARK_RESET, TS_RESET);
    exp_park[0] = 2'd1; exp_park[2] = 2'd1; exp_mode = '0;
    check_tms("R6");
    check_route("R6", 2);
    load_mode(8'h07);
    check_route("R10", 4);
    step(OP_UNPARK, TS_IDLE);
    check_tms("R9");
    step(OP_UNPARK, TS_RESET);
    exp_park[0] = 2'd0; exp_park[2] = 2'd0; exp_mode = '0;
    check_tms("R9");
    check_route("R6", 2);
    load_mode(8'h07);
    check_route("R4", 5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule